// File: doc/BRIEF.md
# Dual-mode BCD hour counter

This block is the hour stage of a real-time clock. It keeps the current hour as a packed BCD value in the low six bits of a byte and steps it by one hour for each carry pulse arriving from the minutes stage. A mode bit chooses between two codings. In 24-hour coding the byte runs from 0x00 through 0x23. In 12-hour coding bit 5 marks PM, bits 4:0 hold the hour 1 to 12 in BCD, and both midnight and noon use the hour value 12.

Software loads the hour and the mode bit through a synchronous write port and reads the stored byte back. Software must set the mode before it writes an hour, because the stored byte is never converted when the mode changes. At the end of each day the block emits a one-cycle day-carry pulse for the date stage.

Top module: `hour_core`

## Requirements
- R1: After reset the hour byte reads 0x12, the mode bit reads 0 (12-hour coding) and the day carry is low.
- R2: With mode 1 (24-hour), each carry pulse advances the byte one step in BCD through 0x00, 0x01 ... 0x09, 0x10 ... 0x19, 0x20 ... 0x23, and 0x23 is followed by 0x00. The new value appears in the cycle after the carry.
- R3: With mode 0 (12-hour), midnight is 0x12. It is followed by 0x01, and the AM hours then run up to 0x11 with bit 5 clear.
- R4: With mode 0, AM 0x11 is followed by noon 0x32. Noon is followed by the PM hours 0x21 through 0x31, which are the AM codes with bit 5 set. 0x31 is followed by 0x12.
- R5: The day-carry output is high for exactly the one cycle after a carry that wraps 0x23 to 0x00 (mode 1) or 0x31 to 0x12 (mode 0), and low at all other times.
- R6: An hour write stores bits 5:0 of the write data, visible in the next cycle. In the same cycle it takes priority over a carry, which is then dropped and raises no day carry.
- R7: A mode write changes only the mode bit. The stored hour byte is kept as it is and is interpreted under the new mode from then on. A carry in the same cycle as a mode write steps under the mode in force before that cycle's edge.
- R8: Bits 7 and 6 of the hour read port always read 0.
- R9: A carry applied to a byte that is not a valid code of the current mode loads the first code of that mode (0x00 in mode 1, 0x12 in mode 0) and raises no day carry.
- R10: Without a carry or an hour write, the hour byte holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| carry_i | input | 1 | One-hour step request from the minutes stage |
| hour_we_i | input | 1 | Hour write strobe |
| hour_wdata_i | input | 8 | Hour write data; bits 5:0 are stored |
| mode_we_i | input | 1 | Mode write strobe |
| mode_wdata_i | input | 1 | New mode: 0 = 12-hour, 1 = 24-hour |
| hour_o | output | 8 | Stored hour byte, bits 7:6 zero |
| mode_o | output | 1 | Current mode bit |
| day_carry_o | output | 1 | One-cycle pulse when the hour wraps to the start of a day |

## Verification
Full days are run in both modes from a written start value. This separates the BCD tens roll-over (0x09 to 0x10, 0x19 to 0x20) from the 12-hour AM to PM turn at 0x11 to 0x32, the noon to 0x21 step and the day wraps. Writes that coincide with carries show the write priority and that the day carry is suppressed. Mode flips with a byte already stored show that no conversion happens and which mode a same-cycle carry uses. Out-of-range bytes (0xFF, 0x1A, 0x00 and 0x15 in 12-hour mode) show the recovery to the first code of each mode and that no day carry follows it. Idle stretches between these patterns confirm that the hour holds.

// File: rtl/hour_pkg.sv
package hour_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned HOUR_W  = 6;
  localparam int unsigned PAD_W   = BYTE_W - HOUR_W;

  localparam logic [HOUR_W-1:0] FIRST_24H = 6'h00;
  localparam logic [HOUR_W-1:0] LAST_24H  = 6'h23;
  localparam logic [HOUR_W-1:0] FIRST_12H = 6'h12;
  localparam logic [HOUR_W-1:0] RESET_HOUR = FIRST_12H;

  typedef enum logic {
    MODE_12H = 1'b0,
    MODE_24H = 1'b1
  } hour_mode_e;
endpackage

// File: rtl/hour_step24.sv
module hour_step24
  import hour_pkg::*;
(
  input  logic [HOUR_W-1:0] cur_i,
  output logic [HOUR_W-1:0] nxt_o,
  output logic              wrap_o
);
  logic [1:0]         tens;
  logic [DIGIT_W-1:0] ones;
  logic               valid;

  assign tens  = cur_i[5:4];
  assign ones  = cur_i[3:0];
  assign valid = (ones <= 4'd9) && (tens <= 2'd2) && !((tens == 2'd2) && (ones > 4'd3));

  always_comb begin
    nxt_o  = FIRST_24H;
    wrap_o = 1'b0;
    if (!valid) begin
      nxt_o = FIRST_24H;
    end else if (cur_i == LAST_24H) begin
      nxt_o  = FIRST_24H;
      wrap_o = 1'b1;
    end else if (ones == 4'd9) begin
      nxt_o = {tens + 2'd1, 4'd0};
    end else begin
      nxt_o = {tens, ones + 4'd1};
    end
  end
endmodule

// File: rtl/hour_step12.sv
module hour_step12
  import hour_pkg::*;
(
  input  logic [HOUR_W-1:0] cur_i,
  output logic [HOUR_W-1:0] nxt_o,
  output logic              wrap_o
);
  logic               pm;
  logic               ten;
  logic [DIGIT_W-1:0] ones;
  logic               valid;

  assign pm   = cur_i[5];
  assign ten  = cur_i[4];
  assign ones = cur_i[3:0];
  // hour 1..12: 01..09 or 10..12
  assign valid = ten ? (ones <= 4'd2) : ((ones >= 4'd1) && (ones <= 4'd9));

  always_comb begin
    nxt_o  = FIRST_12H;
    wrap_o = 1'b0;
    if (!valid) begin
      nxt_o = FIRST_12H;
    end else if (ten && (ones == 4'd2)) begin
      nxt_o = {pm, 1'b0, 4'd1};          // 12 -> 1, same half
    end else if (ten && (ones == 4'd1)) begin
      nxt_o  = {~pm, 1'b1, 4'd2};        // 11 -> 12, half flips
      wrap_o = pm;
    end else if (ones == 4'd9) begin
      nxt_o = {pm, 1'b1, 4'd0};
    end else begin
      nxt_o = {pm, ten, ones + 4'd1};
    end
  end
endmodule

// File: rtl/hour_core.sv
module hour_core
  import hour_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              carry_i,
  input  logic              hour_we_i,
  input  logic [BYTE_W-1:0] hour_wdata_i,
  input  logic              mode_we_i,
  input  logic              mode_wdata_i,
  output logic [BYTE_W-1:0] hour_o,
  output logic              mode_o,
  output logic              day_carry_o
);
  logic [HOUR_W-1:0] hour_q;
  hour_mode_e        mode_q;
  logic              day_q;

  logic [HOUR_W-1:0] nxt24, nxt12, nxt_sel;
  logic              wrap24, wrap12, wrap_sel;

  hour_step24 i_step24 (
    .cur_i  (hour_q),
    .nxt_o  (nxt24),
    .wrap_o (wrap24)
  );

  hour_step12 i_step12 (
    .cur_i  (hour_q),
    .nxt_o  (nxt12),
    .wrap_o (wrap12)
  );

  assign nxt_sel  = (mode_q == MODE_24H) ? nxt24  : nxt12;
  assign wrap_sel = (mode_q == MODE_24H) ? wrap24 : wrap12;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hour_q <= RESET_HOUR;
      mode_q <= MODE_12H;
      day_q  <= 1'b0;
    end else begin
      day_q <= 1'b0;
      if (hour_we_i) begin
        hour_q <= hour_wdata_i[HOUR_W-1:0];
      end else if (carry_i) begin
        hour_q <= nxt_sel;
        day_q  <= wrap_sel;
      end
      if (mode_we_i) begin
        mode_q <= hour_mode_e'(mode_wdata_i);
      end
    end
  end

  assign hour_o      = {{PAD_W{1'b0}}, hour_q};
  assign mode_o      = mode_q;
  assign day_carry_o = day_q;
endmodule

// File: rtl/hour_core_chk.sv
module hour_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       carry_i,
  input logic       hour_we_i,
  input logic [7:0] hour_wdata_i,
  input logic       mode_we_i,
  input logic       mode_wdata_i,
  input logic [7:0] hour_o,
  input logic       mode_o,
  input logic       day_carry_o
);
  a_r6_write_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hour_we_i |=> (hour_o == {2'b00, $past(hour_wdata_i[5:0])}));

  a_r6_write_no_day: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hour_we_i |=> !day_carry_o);

  a_r5_day_needs_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_carry_o |-> ($past(carry_i) && !$past(hour_we_i)));

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_carry_o |=> !day_carry_o);

  a_r5_day_lands_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_carry_o |-> (hour_o == ($past(mode_o) ? 8'h00 : 8'h12)));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!carry_i && !hour_we_i) |=> $stable(hour_o));

  a_r7_mode_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> (mode_o == $past(mode_wdata_i)));

  a_r2_range_24h: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_i && !hour_we_i && mode_o) |=> ((hour_o <= 8'h23) && (hour_o[3:0] <= 4'd9)));

  a_r3_range_12h: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_i && !hour_we_i && !mode_o) |=>
      (hour_o[4] ? (hour_o[3:0] <= 4'd2) : ((hour_o[3:0] >= 4'd1) && (hour_o[3:0] <= 4'd9))));
endmodule

bind hour_core hour_core_chk i_hour_core_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .carry_i      (carry_i),
  .hour_we_i    (hour_we_i),
  .hour_wdata_i (hour_wdata_i),
  .mode_we_i    (mode_we_i),
  .mode_wdata_i (mode_wdata_i),
  .hour_o       (hour_o),
  .mode_o       (mode_o),
  .day_carry_o  (day_carry_o)
);

// File: tb/test_hour_core.sv
`timescale 1ns/1ps
module test_hour_core;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       carry_i = 1'b0;
  logic       hour_we_i = 1'b0;
  logic [7:0] hour_wdata_i = 8'h00;
  logic       mode_we_i = 1'b0;
  logic       mode_wdata_i = 1'b0;
  logic [7:0] hour_o;
  logic       mode_o;
  logic       day_carry_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int exp_hour = 8'h12;
  bit exp_mode = 1'b0;
  bit exp_day  = 1'b0;

  always #5 clk_i = ~clk_i;

  hour_core i_hour_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .carry_i      (carry_i),
    .hour_we_i    (hour_we_i),
    .hour_wdata_i (hour_wdata_i),
    .mode_we_i    (mode_we_i),
    .mode_wdata_i (mode_wdata_i),
    .hour_o       (hour_o),
    .mode_o       (mode_o),
    .day_carry_o  (day_carry_o)
  );

  // hour of day 0..23 from a code, -1 when the code is not valid in that mode
  function automatic int decode(int b, bit m);
    int t, o, h;
    o = b % 16;
    if (o > 9) return -1;
    if (m) begin
      t = b / 16;
      h = t * 10 + o;
      if (t > 2 || h > 23) return -1;
      return h;
    end
    t = (b / 16) % 2;
    h = t * 10 + o;
    if (h < 1 || h > 12) return -1;
    return (h % 12) + (((b / 32) % 2) ? 12 : 0);
  endfunction

  function automatic int encode(int h, bit m);
    int h12;
    if (m) return (h / 10) * 16 + (h % 10);
    h12 = h % 12;
    if (h12 == 0) h12 = 12;
    return ((h >= 12) ? 32 : 0) + (h12 / 10) * 16 + (h12 % 10);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one clock with the given inputs; model update, then compare at the negedge
  task automatic step(string tag, bit c, bit w = 1'b0, int d = 0, bit wm = 1'b0, bit md = 1'b0);
    int h;
    carry_i = c; hour_we_i = w; hour_wdata_i = d[7:0];
    mode_we_i = wm; mode_wdata_i = md;
    exp_day = 1'b0;
    if (w) begin
      exp_hour = d % 64;
    end else if (c) begin
      h = decode(exp_hour, exp_mode);
      if (h < 0) exp_hour = encode(0, exp_mode);
      else begin
        if (h == 23) exp_day = 1'b1;
        exp_hour = encode((h + 1) % 24, exp_mode);
      end
    end
    if (wm) exp_mode = md;
    @(posedge clk_i);
    @(negedge clk_i);
    carry_i = 1'b0; hour_we_i = 1'b0; mode_we_i = 1'b0;
    check(tag, "hour", int'(hour_o), exp_hour);
    check(tag, "mode", int'(mode_o), int'(exp_mode));
    check(tag, "day_carry", int'(day_carry_o), int'(exp_day));
  endtask

  task automatic expect_hour(string tag, int v);
    check(tag, "literal hour", int'(hour_o), v);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1", "hour", int'(hour_o), 8'h12);
    check("R1", "mode", int'(mode_o), 0);
    check("R1", "day_carry", int'(day_carry_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 full 24-hour day plus wrap
    step("R7", 1'b0, 1'b0, 0, 1'b1, 1'b1);
    step("R6", 1'b0, 1'b1, 8'h00);
    for (int i = 0; i < 26; i++) step("R2", 1'b1);
    expect_hour("R2", 8'h02);
    step("R10", 1'b0);
    step("R10", 1'b0);

    // R3 R4 full 12-hour day from midnight
    step("R7", 1'b0, 1'b0, 0, 1'b1, 1'b0);
    step("R6", 1'b0, 1'b1, 8'h12);
    for (int i = 0; i < 11; i++) step("R3", 1'b1);
    expect_hour("R3", 8'h11);
    step("R4", 1'b1);
    expect_hour("R4", 8'h32);
    for (int i = 0; i < 11; i++) step("R4", 1'b1);
    expect_hour("R4", 8'h31);
    step("R5", 1'b1);
    expect_hour("R5", 8'h12);
    check("R5", "literal day", int'(day_carry_o), 1);
    step("R5", 1'b1);

    // R6 write wins over carry, no day pulse
    step("R6", 1'b0, 1'b1, 8'h31);
    step("R6", 1'b1, 1'b1, 8'h31);
    expect_hour("R6", 8'h31);
    step("R6", 1'b1, 1'b1, 8'h05);
    // R8 upper bits
    step("R8", 1'b0, 1'b1, 8'hFF);
    expect_hour("R8", 8'h3F);
    // R9 invalid codes in 12-hour mode
    step("R9", 1'b1);
    expect_hour("R9", 8'h12);
    step("R9", 1'b0, 1'b1, 8'h1A);
    step("R9", 1'b1);
    step("R9", 1'b0, 1'b1, 8'h00);
    step("R9", 1'b1);
    step("R9", 1'b0, 1'b1, 8'h13);
    step("R9", 1'b1);

    // R7 no conversion on mode change
    step("R7", 1'b0, 1'b0, 0, 1'b1, 1'b1);
    step("R7", 1'b0, 1'b1, 8'h15);
    step("R7", 1'b0, 1'b0, 0, 1'b1, 1'b0);
    expect_hour("R7", 8'h15);
    step("R9", 1'b1);
    step("R7", 1'b0, 1'b1, 8'h10);
    step("R7", 1'b1, 1'b0, 0, 1'b1, 1'b1);  // carry uses 12-hour rule
    expect_hour("R7", 8'h11);
    step("R7", 1'b1);                        // now 24-hour
    expect_hour("R7", 8'h12);
    step("R7", 1'b0, 1'b1, 8'h32);
    step("R7", 1'b1, 1'b0, 0, 1'b1, 1'b0);  // 0x32 invalid under 24-hour
    expect_hour("R9", 8'h00);
    step("R9", 1'b1);                        // 0x00 invalid under 12-hour
    // R9 invalid in 24-hour mode
    step("R9", 1'b0, 1'b0, 0, 1'b1, 1'b1);
    step("R9", 1'b0, 1'b1, 8'h24);
    step("R9", 1'b1);
    step("R9", 1'b0, 1'b1, 8'h3F);
    step("R9", 1'b1);
    // R5 wrap in 24-hour with held carry
    step("R5", 1'b0, 1'b1, 8'h22);
    for (int i = 0; i < 4; i++) step("R5", 1'b1);
    for (int i = 0; i < 3; i++) step("R10", 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule